// File: doc/BRIEF.md
# Converter Reset and Init Sequencer

This block sequences the digital side of a stereo audio converter through power-down and start-up. An active-low power-down input holds the ADC and DAC data paths in reset. It may arrive as a short asynchronous pulse. When the input is released, the DAC path leaves reset at once. The ADC path is first aligned to the next rising edge of the frame clock. It then waits through a fixed settling period of 516 frame-clock rising edges before its sample words are declared valid. Until then, every ADC word leaving the block is forced to zero.

The sequencer is a four-state machine:

- `ST_DOWN`: everything held in reset.
- `ST_ALIGN`: DAC running, ADC held until the first frame edge.
- `ST_INIT`: ADC running, output gated to zero, counting frame edges.
- `ST_RUN`: ADC words pass through.

The named transitions are:

- `T_RELEASE` (DOWN→ALIGN): the synchronized power-down release.
- `T_ALIGN` (ALIGN→INIT): the first frame rising edge.
- `T_SETTLED` (INIT→RUN): the 516th frame rising edge.
- `T_POWERDOWN` (any→DOWN): asynchronous, when power-down goes low.

Top module: `conv_init_seq`

## Requirements
- R1: While `pdn_n` is low, `dac_rst_n`, `adc_rst_n` and `adc_valid` are low. They fall without waiting for a clock edge.
- R2: While `adc_valid` is low, `adc_word_out` is all zero, whatever the value of `adc_word_in`.
- R3: `adc_valid` rises within 3 clock cycles of the 516th rising edge of `frame_clk` after release, counting the aligning edge as the first. It does not rise before that edge.
- R4: `dac_rst_n` rises within 3 clock cycles of `pdn_n` rising, with no frame-clock edge needed.
- R5: `adc_rst_n` stays low after release until the first `frame_clk` rising edge. It rises within 3 clock cycles of that edge, and never while `dac_rst_n` is low.
- R6: While `adc_valid` is high, `adc_word_out` equals `adc_word_in` in the same cycle.
- R7: A low pulse on `pdn_n`, even one shorter than a clock period, clears the edge count. A full 516-edge wait then restarts after the next release.
- R8: Once high, `adc_valid` stays high for as long as `pdn_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pdn_n | input | 1 | Asynchronous active-low power-down |
| frame_clk | input | 1 | Frame (left/right) clock, asynchronous to clk, slower than clk/6 |
| adc_word_in | input | WORD_W (20) | Raw ADC sample word, two's complement |
| adc_word_out | output | WORD_W (20) | Gated ADC sample word |
| adc_valid | output | 1 | ADC output settled and valid |
| adc_rst_n | output | 1 | Active-low reset for the ADC path |
| dac_rst_n | output | 1 | Active-low reset for the DAC path |

## Verification
A wrong internal state shows up directly at the ports:

- A state machine stuck in or skipping `ST_ALIGN` shows as `adc_rst_n` rising either before any frame edge or never. This is visible within three cycles of the first frame edge.
- A counter that is off by one, not cleared by a short power-down pulse, or saturating at the wrong value moves the rise of `adc_valid`. This shows within three cycles of the 516th edge, or as an early rise during the wait.
- A faulty gate shows at once as non-zero words during initialization, or as altered words afterwards.

// File: rtl/conv_init_pkg.sv
package conv_init_pkg;
    typedef enum logic [1:0] {
        ST_DOWN  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_INIT  = 2'd2,
        ST_RUN   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/pd_sync.sv
// Asynchronous assert, synchronous release of the power-down input.
module pd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pdn_n,
    output logic rst_sync_n
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/frame_edge.sv
// Brings the frame clock into the clk domain and flags its rising edges.
module frame_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic frame_clk,
    output logic rise
);
    logic [STAGES:0] taps;

    always_ff @(posedge clk) begin
        taps <= {taps[STAGES-1:0], frame_clk};
    end

    assign rise = taps[STAGES-1] & ~taps[STAGES];
endmodule

// File: rtl/init_counter.sv
// Saturating count of frame edges during ADC settling.
module init_counter #(
    parameter int LIMIT = 516,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load1,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (load1)
            count <= CW'(1);
        else if (inc && count != CW'(LIMIT))
            count <= count + CW'(1);
    end
endmodule

// File: rtl/conv_init_seq.sv
module conv_init_seq
    import conv_init_pkg::*;
#(
    parameter int WORD_W      = 20,
    parameter int INIT_EDGES  = 516,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(INIT_EDGES + 1)
) (
    input  logic              clk,
    input  logic              pdn_n,
    input  logic              frame_clk,
    input  logic [WORD_W-1:0] adc_word_in,
    output logic [WORD_W-1:0] adc_word_out,
    output logic              adc_valid,
    output logic              adc_rst_n,
    output logic              dac_rst_n
);
    seq_state_e       state_q, state_d;
    logic             pd_rst_n;
    logic             frame_rise;
    logic [CNT_W-1:0] edge_cnt;
    logic             last_edge;

    pd_sync #(.STAGES(SYNC_STAGES)) u_pd_sync (
        .clk        (clk),
        .pdn_n      (pdn_n),
        .rst_sync_n (pd_rst_n)
    );

    frame_edge #(.STAGES(SYNC_STAGES)) u_frame_edge (
        .clk       (clk),
        .frame_clk (frame_clk),
        .rise      (frame_rise)
    );

    init_counter #(.LIMIT(INIT_EDGES)) u_init_counter (
        .clk   (clk),
        .rst_n (pd_rst_n),
        .load1 (frame_rise && state_q == ST_ALIGN),
        .inc   (frame_rise && state_q == ST_INIT),
        .count (edge_cnt)
    );

    assign last_edge = frame_rise && (edge_cnt == CNT_W'(INIT_EDGES - 1));

    // State register: T_POWERDOWN is the asynchronous clear.
    always_ff @(posedge clk or negedge pd_rst_n) begin
        if (!pd_rst_n) state_q <= ST_DOWN;
        else           state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DOWN:  state_d = ST_ALIGN;                         // T_RELEASE
            ST_ALIGN: if (frame_rise) state_d = ST_INIT;          // T_ALIGN
            ST_INIT:  if (last_edge)  state_d = ST_RUN;           // T_SETTLED
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_DOWN;
        endcase
    end

    // Output decode
    always_comb begin
        dac_rst_n = 1'b0;
        adc_rst_n = 1'b0;
        adc_valid = 1'b0;
        unique case (state_q)
            ST_DOWN:  ;
            ST_ALIGN: dac_rst_n = 1'b1;
            ST_INIT:  begin dac_rst_n = 1'b1; adc_rst_n = 1'b1; end
            ST_RUN:   begin dac_rst_n = 1'b1; adc_rst_n = 1'b1; adc_valid = 1'b1; end
            default:  ;
        endcase
    end

    assign adc_word_out = adc_valid ? adc_word_in : '0;
endmodule

// File: rtl/conv_init_seq_chk.sv
module conv_init_seq_chk #(
    parameter int WORD_W = 20
) (
    input logic              clk,
    input logic              rst_sync_n,
    input logic              adc_rst_n,
    input logic              dac_rst_n,
    input logic              adc_valid,
    input logic [WORD_W-1:0] adc_word_out
);
    AST_RESET_HOLDS_DAC: assert property (@(posedge clk)
        !rst_sync_n |-> (!dac_rst_n && !adc_rst_n && !adc_valid)); // R1

    AST_GATE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !adc_rst_n |-> (adc_word_out == '0)); // R2

    AST_VALID_NEEDS_PATHS: assert property (@(posedge clk) disable iff (!rst_sync_n)
        adc_valid |-> (adc_rst_n && dac_rst_n)); // R3

    AST_ADC_AFTER_DAC: assert property (@(posedge clk) disable iff (!rst_sync_n)
        adc_rst_n |-> dac_rst_n); // R5

    AST_ADC_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rst_sync_n)
        $rose(adc_rst_n) |-> $past(dac_rst_n)); // R5

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
        adc_valid |=> adc_valid); // R8
endmodule

bind conv_init_seq conv_init_seq_chk #(.WORD_W(WORD_W)) chk_i (
    .clk          (clk),
    .rst_sync_n   (pd_rst_n),
    .adc_rst_n    (adc_rst_n),
    .dac_rst_n    (dac_rst_n),
    .adc_valid    (adc_valid),
    .adc_word_out (adc_word_out)
);

// File: tb/conv_init_seq_tb.sv
`timescale 1ns/1ps
module conv_init_seq_tb_top;
    localparam int W     = 20;
    localparam int EDGES = 516;

    logic         clk = 1'b0;
    logic         pdn_n = 1'b0;
    logic         frame_clk = 1'b0;
    logic [W-1:0] adc_word_in = '0;
    logic [W-1:0] adc_word_out;
    logic         adc_valid, adc_rst_n, dac_rst_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    conv_init_seq dut_i (
        .clk          (clk),
        .pdn_n        (pdn_n),
        .frame_clk    (frame_clk),
        .adc_word_in  (adc_word_in),
        .adc_word_out (adc_word_out),
        .adc_valid    (adc_valid),
        .adc_rst_n    (adc_rst_n),
        .dac_rst_n    (dac_rst_n)
    );

    function automatic logic [W-1:0] exp_word(input logic valid, input logic [W-1:0] raw);
        return valid ? raw : '0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic new_word();
        adc_word_in = W'($urandom);
    endtask

    // Releases power-down with frame_clk low and runs n_frames frames.
    task automatic init_run(input int half, input int n_frames);
        @(negedge clk);
        pdn_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 dac_rst_n after release", 32'(dac_rst_n), 1);
        chk("R5 adc_rst_n before first frame edge", 32'(adc_rst_n), 0);
        for (int k = 1; k <= n_frames; k++) begin
            frame_clk = 1'b1;
            if (k == EDGES) chk("R3 valid not before last edge", 32'(adc_valid), 0);
            repeat (3) @(negedge clk);
            if (k == 1) chk("R5 adc_rst_n after first edge", 32'(adc_rst_n), 1);
            chk("R3 valid vs edge count", 32'(adc_valid), (k >= EDGES) ? 1 : 0);
            if (k % 97 == 0) begin
                new_word();
                #1;
                chk("R2 word gated during init", 32'(adc_word_out), 32'(exp_word(1'b0, adc_word_in)));
            end
            repeat (half - 3) @(negedge clk);
            frame_clk = 1'b0;
            repeat (half) @(negedge clk);
        end
    endtask

    task automatic run_frames(input int half, input int n);
        for (int k = 0; k < n; k++) begin
            frame_clk = 1'b1;
            repeat (half) @(negedge clk);
            frame_clk = 1'b0;
            repeat (half) @(negedge clk);
            chk("R8 valid stays high", 32'(adc_valid), 1);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        // Reset state, with frames and data toggling during power-down
        for (int k = 0; k < 3; k++) begin
            frame_clk = 1'b1; new_word();
            repeat (4) @(negedge clk);
            frame_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
        chk("R1 dac_rst_n in power-down", 32'(dac_rst_n), 0);
        chk("R1 adc_rst_n in power-down", 32'(adc_rst_n), 0);
        chk("R1 valid in power-down", 32'(adc_valid), 0);
        chk("R2 word zero in power-down", 32'(adc_word_out), 0);

        // First full initialization
        init_run(4 + int'($urandom % 4), EDGES);
        for (int k = 0; k < 8; k++) begin
            new_word();
            #1;
            chk("R6 word passes when valid", 32'(adc_word_out), 32'(exp_word(1'b1, adc_word_in)));
            @(negedge clk);
        end
        adc_word_in = {1'b0, {(W-1){1'b1}}}; #1;
        chk("R6 max positive word", 32'(adc_word_out), 32'h7FFFF);
        adc_word_in = {1'b1, {(W-1){1'b0}}}; #1;
        chk("R6 max negative word", 32'(adc_word_out), 32'h80000);
        run_frames(5, 30);

        // Short power-down pulse, shorter than one clock period
        @(negedge clk);
        #1 pdn_n = 1'b0;
        #2;
        chk("R1 async dac reset", 32'(dac_rst_n), 0);
        chk("R1 async adc reset", 32'(adc_rst_n), 0);
        chk("R7 valid cleared by short pulse", 32'(adc_valid), 0);
        #1 pdn_n = 1'b1;
        @(negedge clk);
        pdn_n = 1'b0;
        repeat (2) @(negedge clk);
        init_run(4 + int'($urandom % 4), EDGES); // R7 full wait again

        // Interrupt part-way through initialization
        pdn_n = 1'b0;
        repeat (5) @(negedge clk);
        init_run(6, 300);
        pdn_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 valid low after mid-init power-down", 32'(adc_valid), 0);
        init_run(4 + int'($urandom % 4), EDGES); // R7 count restarted
        run_frames(4, 5);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule